// File: doc/BRIEF.md
# Variable-Latency Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns a 2*WIDTH-bit product using a single adder. It keeps the multiplicand in a holding register and the multiplier in a register that shifts right. A double-width product register also shifts right, one position per step. The block looks at the low bit of the multiplier once per step. A one bit costs an add clock followed by a shift clock. A zero bit costs only a shift clock, so the run time depends on how many ones the multiplier holds.

A request is a one-cycle `start_i` together with both operands while `busy_o` is low. The result appears on `product_o` with a one-cycle `done_o` strobe. The product stays on the port until the next accepted request.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: When `done_o` is high, `product_o` equals the unsigned product of the operands that were accepted.
- R3: `done_o` rises exactly WIDTH plus the number of one bits in the multiplier clock cycles after the edge that accepted the request.
- R4: `done_o` is high for exactly one cycle per accepted request.
- R5: `busy_o` is high from the cycle after an accepted start until the last step, and it is low in the cycle where `done_o` is high.
- R6: A `start_i` pulse seen while `busy_o` is high is ignored. The running result, its timing and the number of `done_o` strobes are unchanged.
- R7: A zero multiplier finishes in exactly WIDTH cycles with a zero product.
- R8: All-ones operands take 2*WIDTH cycles and give the full-width product, which relies on the adder carry being shifted into the product MSB.
- R9: After `done_o`, `product_o` keeps its value until a new start is accepted. A start is accepted in the `done_o` cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, honoured only while not busy |
| multiplicand_i | input | WIDTH | Operand held for the adds |
| multiplier_i | input | WIDTH | Operand whose bits select the adds |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle result strobe |
| product_o | output | 2*WIDTH | Unsigned product |

## Verification
The hardest case to reach from the ports is a start request that lands while a multiplication is running. A design that wrongly accepts it would corrupt the operands in flight or emit an extra strobe. The bench therefore pulses `start_i` with different operands during an active run. A scoreboard that only expects strobes for accepted requests then catches any stray `done_o`, wrong product or shifted timing. Back-to-back requests issued in the `done_o` cycle, together with all-ones and zero multipliers, exercise the carry path and both ends of the latency range.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_SHIFT = 2'd2
  } mul_state_e;
endpackage

// File: rtl/shift_add_mul_adder.sv
module shift_add_mul_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_rca
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end
  assign sum_o[WIDTH] = carry[WIDTH];
endmodule

// File: rtl/shift_add_mul_ctrl.sv
module shift_add_mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lsb_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e    state_q;
  logic [CW-1:0] count_q;
  logic          done_q;
  logic          last_step;

  assign last_step = (count_q == LAST);
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign add_o     = (state_q == ST_STEP) && lsb_i;
  assign shift_o   = ((state_q == ST_STEP) && !lsb_i) || (state_q == ST_SHIFT);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        state_q <= ST_STEP;
        count_q <= '0;
      end else if (add_o) begin
        state_q <= ST_SHIFT;
      end else if (shift_o) begin
        if (last_step) begin
          state_q <= ST_IDLE;
          count_q <= '0;
          done_q  <= 1'b1;
        end else begin
          state_q <= ST_STEP;
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (count_q <= LAST));

  // zero bit: single-clock step, bit counter advances
  p_zero_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STEP && !lsb_i && !last_step) |=>
      (state_q == ST_STEP && count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/shift_add_mul_dp.sv
module shift_add_mul_dp #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               add_i,
  input  logic               shift_i,
  input  logic               busy_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               lsb_o,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplier_q;
  logic [PW-1:0]    prod_q;
  logic             carry_q;
  logic [WIDTH:0]   sum;

  shift_add_mul_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i  (prod_q[PW-1:WIDTH]),
    .b_i  (mcand_q),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
      carry_q  <= 1'b0;
    end else if (load_i) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      prod_q   <= '0;
      carry_q  <= 1'b0;
    end else if (add_i) begin
      {carry_q, prod_q[PW-1:WIDTH]} <= sum;
    end else if (shift_i) begin
      prod_q   <= {carry_q, prod_q[PW-1:1]};
      mplier_q <= {1'b0, mplier_q[WIDTH-1:1]};
      carry_q  <= 1'b0;
    end
  end

  assign lsb_o  = mplier_q[0];
  assign prod_o = prod_q;

  p_add_then_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> (shift_i && !add_i));

  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !load_i) |=> $stable(mcand_q));

  p_hold_product_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !load_i) |=> $stable(prod_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, add, shift, lsb;

  shift_add_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .lsb_i  (lsb),
    .load_o (load),
    .add_o  (add),
    .shift_o(shift),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  shift_add_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .add_i   (add),
    .shift_i (shift),
    .busy_i  (busy_o),
    .mcand_i (multiplicand_i),
    .mplier_i(multiplier_i),
    .lsb_o   (lsb),
    .prod_o  (product_o)
  );
endmodule

// File: tb/shift_add_mul_tb_top.sv
`timescale 1ns/1ps
module shift_add_mul_tb_top;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  typedef struct {
    logic [PW-1:0] prod;
    int            lat;
    int            t0;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int   n_checks = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   ended = 1'b0;
  bit   prev_done = 1'b0;
  logic [PW-1:0] last_prod = '0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shift_add_mul #(.WIDTH(W)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .multiplicand_i(mcand),
    .multiplier_i  (mplier),
    .busy_o        (busy),
    .done_o        (done),
    .product_o     (product)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // driver: waits for idle, issues request, pushes expectation
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(posedge clk);
    #1;
    e.prod = PW'(a) * PW'(b);
    e.lat  = W + $countones(b);
    e.t0   = cyc;
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", 64'(busy), 64'd1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        check(!done, "R4 done single cycle", 64'(done), 64'd0);
      if (done) begin
        check(!busy, "R5 busy low with done", 64'(busy), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(product == e.prod, {"R2 product ", e.tag}, 64'(product), 64'(e.prod));
          check((cyc - e.t0) == e.lat, {"R3 latency ", e.tag}, 64'(cyc - e.t0), 64'(e.lat));
          last_prod = e.prod;
        end
      end
      prev_done = done;
    end
  end

  task automatic wait_drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R2 queue drained", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
    check(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    check(product == '0, "R1 product in reset", 64'(product), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset",
          {61'd0, busy, done, |product}, 64'd0);

    drive(8'h5B, 8'h00, "R7 zero multiplier");
    drive(8'h00, 8'hA7, "R2 zero multiplicand");
    drive(8'hFF, 8'hFF, "R8 all ones");
    drive(8'h01, 8'h01, "R2 unit");
    drive(8'h80, 8'h80, "R2 top bits");
    drive(8'hAA, 8'h55, "R3 alternating");
    drive(8'hFF, 8'h80, "R3 single one high");
    wait_drain();

    // R9: product held while idle
    repeat (6) @(negedge clk);
    check(product == last_prod, "R9 hold after done", 64'(product), 64'(last_prod));

    // R6: start pulses during a running multiply
    drive(8'hC3, 8'h5A, "R6 in-flight");
    start = 1'b1; mcand = 8'h11; mplier = 8'hFF;
    @(negedge clk);
    mcand = 8'h77; mplier = 8'h00;
    @(negedge clk);
    start = 1'b0;
    wait_drain();

    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[7:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[15:8];
      drive(a, b, "R9 back-to-back");
    end
    wait_drain();

    repeat (3 * W) @(negedge clk);
    check(product == last_prod, "R9 final hold", 64'(product), 64'(last_prod));
    finish_run();
  end
endmodule